// File: doc/BRIEF.md
# Memory Request Alignment and Fault Classifier

This block sits between a processor core's memory request port and the memory fabric. Each request is an instruction fetch, a load or a store. For each one the block checks alignment. A request that passes is forwarded one cycle later to one of several address-range handlers, or to default memory. An alignment failure is not forwarded. Instead the block raises a one-cycle trap pulse that carries a RISC-V exception cause code and the faulting address.

The block keeps track of the one request that is outstanding. When the fabric answers that request with an error, the block turns the answer into an access-fault cause code, paired with the address of the original request. Requests tagged as debug accesses bypass the alignment check and never produce a trap. Trap entry itself is done by a separate unit that consumes the trap pulse. Address translation and memory contents are outside this block.

Usage contract: at most one forwarded request is outstanding at a time. The core never presents a request in the same cycle as a response.

Top module: `mrq_fault_classifier`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `mem_valid` and `trap_valid` are low.
- R2: A non-debug fetch (kind code 0) must be 2-byte aligned when `compressed_en` is 1, and 4-byte aligned when it is 0. The fetch size field is ignored.
- R3: A non-debug load or store of size code s (access of 2^s bytes) must be aligned to min(2^s, XLEN/8) bytes. A single-byte access is therefore never misaligned.
- R4: A misaligned non-debug request raises `trap_valid` in the cycle after the request, with `trap_addr` equal to the request address and `mem_valid` low. The cause is 0 for a fetch, 6 for a store (kind code 2), and 4 for a load (kind code 1; kind code 3 is handled as a load).
- R5: An accepted request appears on the `mem_*` outputs in the cycle after it is presented, with the same address, kind, size and debug tag.
- R6: A forwarded load or store gets `mem_sel` equal to the lowest range index i for which base_i <= address < base_i + size_i. If no range matches, `mem_sel` equals NUM_RANGES (default memory). A fetch always gets NUM_RANGES.
- R7: An error response (`rsp_valid` and `rsp_err`) to a non-debug request raises `trap_valid` in the following cycle, with `trap_addr` equal to that request's address. The cause is 5 for a load, 7 for a store and 1 for a fetch.
- R8: A response without error raises no trap.
- R9: A debug-tagged request skips the alignment check, is always forwarded, and raises no trap even when its response carries an error.
- R10: Each fault gives a `trap_valid` pulse one cycle long. `trap_valid` and `mem_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| compressed_en | input | 1 | 1: fetch needs 2-byte alignment; 0: 4-byte |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as load |
| req_size | input | 2 | log2 of access bytes |
| req_addr | input | AW | Request byte address |
| req_debug | input | 1 | Debug-tagged request |
| mem_valid | output | 1 | Forwarded request valid |
| mem_sel | output | SELW | Target range index; NUM_RANGES means default memory |
| mem_kind | output | 2 | Forwarded kind |
| mem_size | output | 2 | Forwarded size code |
| mem_addr | output | AW | Forwarded address |
| mem_debug | output | 1 | Forwarded debug tag |
| rsp_valid | input | 1 | Response for the outstanding request |
| rsp_err | input | 1 | Response carries an error |
| trap_valid | output | 1 | One-cycle fault pulse |
| trap_cause | output | 4 | Exception cause code |
| trap_addr | output | AW | Faulting address |

## Verification
Some properties are checked on every cycle by the assertions. Single-byte data requests are always forwarded. Debug requests are always forwarded without a trap. Fetches never leave default memory. An error response to a tracked non-debug request always traps with the tracked address. Clean responses never trap. Forwarding and trapping never overlap. Other behaviour can only be shown by the bench's sweeps over kind, size, address offset, compression setting and debug tag: the exact cause codes, the alignment boundary for each size, and the first-match priority where two ranges overlap.

// File: rtl/mrq_pkg.sv
package mrq_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_LOADX = 2'd3
  } mrq_kind_e;

  localparam logic [3:0] CAUSE_FETCH_MISAL = 4'd0;
  localparam logic [3:0] CAUSE_FETCH_FAULT = 4'd1;
  localparam logic [3:0] CAUSE_LOAD_MISAL  = 4'd4;
  localparam logic [3:0] CAUSE_LOAD_FAULT  = 4'd5;
  localparam logic [3:0] CAUSE_STORE_MISAL = 4'd6;
  localparam logic [3:0] CAUSE_STORE_FAULT = 4'd7;
endpackage

// File: rtl/mrq_align_chk.sv
module mrq_align_chk
  import mrq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int XLEN_BYTES = 4
) (
  input  logic [1:0]    kind,
  input  logic [1:0]    size,
  input  logic [AW-1:0] addr,
  input  logic          compressed_en,
  output logic          misaligned,
  output logic [3:0]    cause
);
  localparam logic [1:0] XLEN_LG = 2'($clog2(XLEN_BYTES));

  logic [1:0] lg;
  logic [2:0] mask;

  always_comb begin
    if (kind == KIND_FETCH) lg = compressed_en ? 2'd1 : 2'd2;
    else if (size > XLEN_LG) lg = XLEN_LG;
    else lg = size;
    mask = 3'((4'd1 << lg) - 4'd1);
    misaligned = |(addr[2:0] & mask);
    case (kind)
      KIND_FETCH: cause = CAUSE_FETCH_MISAL;
      KIND_STORE: cause = CAUSE_STORE_MISAL;
      default:    cause = CAUSE_LOAD_MISAL;
    endcase
  end

  // a_r3_byte_aligned: a one-byte data access is never flagged
  always_comb begin
    if (kind != KIND_FETCH && size == 2'd0)
      a_r3_byte_aligned: assert (!misaligned);
  end
endmodule

// File: rtl/mrq_range_dec.sv
module mrq_range_dec #(
  parameter int AW         = 32,
  parameter int NUM_RANGES = 3,
  parameter logic [NUM_RANGES*AW-1:0] RANGE_BASE = '0,
  parameter logic [NUM_RANGES*AW-1:0] RANGE_SIZE = '0,
  parameter int SELW       = $clog2(NUM_RANGES + 1)
) (
  input  logic [AW-1:0]   addr,
  input  logic            use_ranges,
  output logic [SELW-1:0] sel
);
  logic [NUM_RANGES-1:0] hit;

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
    logic [AW:0] lo, hi, a;
    assign lo = {1'b0, RANGE_BASE[g*AW +: AW]};
    assign hi = lo + {1'b0, RANGE_SIZE[g*AW +: AW]};
    assign a  = {1'b0, addr};
    assign hit[g] = (a >= lo) && (a < hi);
  end

  always_comb begin
    sel = SELW'(NUM_RANGES);
    if (use_ranges) begin
      for (int i = NUM_RANGES - 1; i >= 0; i--)
        if (hit[i]) sel = SELW'(i);
    end
  end

  // a_r6_no_range_for_fetch
  always_comb begin
    if (!use_ranges) a_r6_no_range_for_fetch: assert (sel == SELW'(NUM_RANGES));
  end
endmodule

// File: rtl/mrq_fault_trk.sv
module mrq_fault_trk
  import mrq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [1:0]    issue_kind,
  input  logic          issue_debug,
  input  logic [AW-1:0] issue_addr,
  input  logic          rsp_valid,
  input  logic          rsp_err,
  input  logic          align_trap,
  input  logic [3:0]    align_cause,
  input  logic [AW-1:0] align_addr,
  output logic          trap_valid,
  output logic [3:0]    trap_cause,
  output logic [AW-1:0] trap_addr
);
  logic          pend_valid;
  logic          pend_debug;
  logic [1:0]    pend_kind;
  logic [AW-1:0] pend_addr;
  logic [3:0]    fault_cause;
  logic          rsp_trap;

  always_comb begin
    case (pend_kind)
      KIND_FETCH: fault_cause = CAUSE_FETCH_FAULT;
      KIND_STORE: fault_cause = CAUSE_STORE_FAULT;
      default:    fault_cause = CAUSE_LOAD_FAULT;
    endcase
    rsp_trap = rsp_valid && rsp_err && pend_valid && !pend_debug;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_debug <= 1'b0;
      pend_kind  <= KIND_FETCH;
      pend_addr  <= '0;
    end else if (issue) begin
      pend_valid <= 1'b1;
      pend_debug <= issue_debug;
      pend_kind  <= issue_kind;
      pend_addr  <= issue_addr;
    end else if (rsp_valid) begin
      pend_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_valid <= 1'b0;
      trap_cause <= '0;
      trap_addr  <= '0;
    end else if (align_trap) begin
      trap_valid <= 1'b1;
      trap_cause <= align_cause;
      trap_addr  <= align_addr;
    end else if (rsp_trap) begin
      trap_valid <= 1'b1;
      trap_cause <= fault_cause;
      trap_addr  <= pend_addr;
    end else begin
      trap_valid <= 1'b0;
    end
  end

  a_r7_error_traps: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err && pend_valid && !pend_debug && !align_trap)
      |=> (trap_valid && trap_addr == $past(pend_addr)));

  a_r8_clean_no_trap: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err && !align_trap) |=> !trap_valid);

  a_r9_debug_rsp_silent: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && pend_debug && !align_trap) |=> !trap_valid);
endmodule

// File: rtl/mrq_fault_classifier.sv
module mrq_fault_classifier
  import mrq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int XLEN_BYTES = 4,
  parameter int NUM_RANGES = 3,
  parameter logic [NUM_RANGES*AW-1:0] RANGE_BASE = {32'h0000_8000, 32'h0000_1080, 32'h0000_1000},
  parameter logic [NUM_RANGES*AW-1:0] RANGE_SIZE = {32'h0000_0040, 32'h0000_0200, 32'h0000_0100},
  localparam int SELW      = $clog2(NUM_RANGES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            compressed_en,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic [1:0]      req_size,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_debug,
  output logic            mem_valid,
  output logic [SELW-1:0] mem_sel,
  output logic [1:0]      mem_kind,
  output logic [1:0]      mem_size,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_debug,
  input  logic            rsp_valid,
  input  logic            rsp_err,
  output logic            trap_valid,
  output logic [3:0]      trap_cause,
  output logic [AW-1:0]   trap_addr
);
  logic            misal;
  logic [3:0]      misal_cause;
  logic [SELW-1:0] sel_d;
  logic            fwd;
  logic            align_trap;

  mrq_align_chk #(.AW(AW), .XLEN_BYTES(XLEN_BYTES)) u_align (
    .kind(req_kind), .size(req_size), .addr(req_addr),
    .compressed_en(compressed_en), .misaligned(misal), .cause(misal_cause)
  );

  mrq_range_dec #(
    .AW(AW), .NUM_RANGES(NUM_RANGES), .RANGE_BASE(RANGE_BASE),
    .RANGE_SIZE(RANGE_SIZE), .SELW(SELW)
  ) u_dec (
    .addr(req_addr), .use_ranges(req_kind != KIND_FETCH), .sel(sel_d)
  );

  assign fwd        = req_valid && (req_debug || !misal);
  assign align_trap = req_valid && !req_debug && misal;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_sel   <= '0;
      mem_kind  <= KIND_FETCH;
      mem_size  <= '0;
      mem_addr  <= '0;
      mem_debug <= 1'b0;
    end else begin
      mem_valid <= fwd;
      if (fwd) begin
        mem_sel   <= sel_d;
        mem_kind  <= req_kind;
        mem_size  <= req_size;
        mem_addr  <= req_addr;
        mem_debug <= req_debug;
      end
    end
  end

  mrq_fault_trk #(.AW(AW)) u_trk (
    .clk(clk), .rst(rst),
    .issue(fwd), .issue_kind(req_kind), .issue_debug(req_debug), .issue_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .align_trap(align_trap), .align_cause(misal_cause), .align_addr(req_addr),
    .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_addr(trap_addr)
  );

  a_r3_byte_forwarded: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind != KIND_FETCH && req_size == 2'd0)
      |=> (mem_valid && mem_addr == $past(req_addr)));

  a_r9_debug_forwarded: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_debug) |=> (mem_valid && !trap_valid));

  a_r6_fetch_default: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == KIND_FETCH) |=> (!mem_valid || mem_sel == SELW'(NUM_RANGES)));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_valid && trap_valid));

  a_r10_contract: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && rsp_valid));
endmodule

// File: tb/mrq_fault_classifier_tb.sv
`timescale 1ns/1ps
module mrq_fault_classifier_tb_top;
  localparam int AW = 32;
  localparam int NR = 3;
  localparam int SELW = $clog2(NR + 1);
  localparam logic [NR*AW-1:0] BASES = {32'h0000_8000, 32'h0000_1080, 32'h0000_1000};
  localparam logic [NR*AW-1:0] SIZES = {32'h0000_0040, 32'h0000_0200, 32'h0000_0100};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic compressed_en = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [1:0] req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_debug = 1'b0;
  logic rsp_valid = 1'b0;
  logic rsp_err = 1'b0;
  logic mem_valid, mem_debug, trap_valid;
  logic [SELW-1:0] mem_sel;
  logic [1:0] mem_kind, mem_size;
  logic [AW-1:0] mem_addr, trap_addr;
  logic [3:0] trap_cause;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mrq_fault_classifier #(.AW(AW), .NUM_RANGES(NR), .RANGE_BASE(BASES), .RANGE_SIZE(SIZES)) dut_i (
    .clk(clk), .rst(rst), .compressed_en(compressed_en),
    .req_valid(req_valid), .req_kind(req_kind), .req_size(req_size),
    .req_addr(req_addr), .req_debug(req_debug),
    .mem_valid(mem_valid), .mem_sel(mem_sel), .mem_kind(mem_kind),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_debug(mem_debug),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_addr(trap_addr)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_sel(input logic [AW-1:0] a, input logic [1:0] k);
    if (k == 2'd0) return NR;
    for (int i = 0; i < NR; i++) begin
      longint b = longint'(BASES[i*AW +: AW]);
      longint s = longint'(SIZES[i*AW +: AW]);
      if (longint'(a) >= b && longint'(a) < b + s) return i;
    end
    return NR;
  endfunction

  task automatic run_req(input logic [1:0] k, input logic [1:0] sz, input logic [AW-1:0] a,
                         input bit dbg, input bit cen, input bit err);
    int lg;
    bit mis;
    int mc, fc;
    lg  = (k == 2'd0) ? (cen ? 1 : 2) : ((sz > 2) ? 2 : int'(sz));
    mis = !dbg && ((int'(a[2:0]) & ((1 << lg) - 1)) != 0);
    mc  = (k == 2'd0) ? 0 : (k == 2'd2) ? 6 : 4;
    fc  = (k == 2'd0) ? 1 : (k == 2'd2) ? 7 : 5;
    @(negedge clk);
    compressed_en = cen; req_valid = 1'b1; req_kind = k; req_size = sz;
    req_addr = a; req_debug = dbg;
    @(negedge clk);
    req_valid = 1'b0;
    if (mis) begin
      check(trap_valid == 1'b1, "R4 misalign trap", trap_valid, 1);
      check(trap_cause == 4'(mc), (k == 2'd0) ? "R2 fetch cause" : "R3 R4 data cause", trap_cause, mc);
      check(trap_addr == a, "R4 trap addr", trap_addr, a);
      check(mem_valid == 1'b0, "R4 suppressed", mem_valid, 0);
      @(negedge clk);
      check(trap_valid == 1'b0, "R10 pulse", trap_valid, 0);
    end else begin
      check(mem_valid == 1'b1, dbg ? "R9 debug fwd" : "R5 forwarded", mem_valid, 1);
      check(trap_valid == 1'b0, "R10 no trap on fwd", trap_valid, 0);
      check({mem_addr, mem_kind, mem_size, mem_debug} == {a, k, sz, dbg}, "R5 fields",
            {mem_addr, mem_kind, mem_size, mem_debug}, {a, k, sz, dbg});
      check(int'(mem_sel) == exp_sel(a, k), "R6 routing", mem_sel, exp_sel(a, k));
      rsp_valid = 1'b1; rsp_err = err;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_err = 1'b0;
      if (err && !dbg) begin
        check(trap_valid == 1'b1, "R7 error trap", trap_valid, 1);
        check(trap_cause == 4'(fc), "R7 fault cause", trap_cause, fc);
        check(trap_addr == a, "R7 fault addr", trap_addr, a);
      end else begin
        check(trap_valid == 1'b0, dbg ? "R9 debug silent" : "R8 clean rsp", trap_valid, 0);
      end
      @(negedge clk);
      check(trap_valid == 1'b0, "R10 pulse end", trap_valid, 0);
    end
  endtask

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd1; req_addr = 32'h1001; req_size = 2'd2;
    @(negedge clk);
    check(mem_valid == 1'b0 && trap_valid == 1'b0, "R1 in reset", {mem_valid, trap_valid}, 0);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(mem_valid == 1'b0 && trap_valid == 1'b0, "R1 after reset", {mem_valid, trap_valid}, 0);

    for (int k = 0; k < 4; k++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off++)
          for (int cen = 0; cen < 2; cen++)
            for (int dbg = 0; dbg < 2; dbg++) begin
              n++;
              run_req(2'(k), 2'(sz), 32'h0000_2000 + 32'(off), bit'(dbg), bit'(cen), bit'(n % 3 == 0));
            end

    begin
      logic [AW-1:0] pts [12] = '{32'h0FFC, 32'h1000, 32'h107C, 32'h1080, 32'h10FC, 32'h1100,
                                  32'h127C, 32'h1280, 32'h7FFC, 32'h8000, 32'h803C, 32'h8040};
      for (int i = 0; i < 12; i++) begin
        run_req(2'd1, 2'd2, pts[i], 1'b0, 1'b0, 1'b1);
        run_req(2'd2, 2'd0, pts[i] + 32'd3, 1'b0, 1'b0, 1'b0);
        run_req(2'd0, 2'd2, pts[i], 1'b0, 1'b1, 1'b0);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule